// File: doc/BRIEF.md
# DMA Sample Fetch Controller

This block is the memory-fetch half of a delta-modulation audio channel. Software programs a start address, a length and two control flags (interrupt enable and loop) through byte-wide register writes. The block then walks the sample in memory one byte at a time. For each byte it raises a DMA request with the current address, takes the returned byte into a one-byte sample buffer, and counts down the bytes still to fetch.

The downstream output unit drains the buffer through a consume strobe. Each consume that leaves bytes outstanding starts the next fetch. When the last byte arrives, the block either restarts the sample from the programmed settings or, if the interrupt is enabled, raises an interrupt line. A channel enable/disable input starts or cancels playback. On an enable, the first request waits two or three cycles depending on the parity of the current cycle.

Top module: `sample_fetch_ctrl`

## Requirements
- R1: `wr_sel` 0 selects the control register. In it, bit 7 enables the interrupt and bit 6 enables looping. A control write with bit 7 clear drops `irq` to 0 on the next cycle.
- R2: A write with `wr_sel` 1 sets the start address to 0xC000 OR (byte << 6). This value appears on `dma_addr` for the first fetch of a sample.
- R3: A write with `wr_sel` 2 sets the sample length to (byte << 4) OR 1 bytes. One sample run issues exactly that many DMA requests.
- R4: A `dma_ack` while bytes remain has these effects on the next cycle: `buf_data` holds `dma_data`, `buf_empty` is 0, `dma_req` is 0, the address has advanced by one and the remaining count has dropped by one.
- R5: The fetch address after 0xFFFF is 0x8000.
- R6: When the last byte is accepted with looping off, no further request is issued. `irq` rises if the interrupt is enabled and stays 0 otherwise.
- R7: When the last byte is accepted with looping on, the address and remaining count reload from the programmed start and length, and `irq` is not raised.
- R8: A disable (`en_wr`=1, `en_val`=0) sets the remaining count to zero and drops `dma_req`. An enable restarts from the programmed start only when no bytes remain; an enable while bytes remain changes nothing.
- R9: After an enable that restarts a sample, `dma_req` rises 2 cycles later if `cyc_odd` was 0 and 3 cycles later if it was 1. It rises only if the buffer is still empty and bytes remain.
- R10: A `buf_take` with a full buffer empties it. If bytes remain, `dma_req` rises on the next cycle. While the buffer is full, `dma_req` stays low.
- R11: `dma_req` and `dma_addr` hold steady until `dma_ack` arrives or the channel is disabled. At most one request is outstanding.
- R12: A `dma_ack` arriving while no bytes remain is ignored: `buf_data` and `buf_empty` are unchanged.
- R13: `rst_hard` sets the start address to 0xC000 and the length to 1. Either reset clears both flags and the remaining count, sets `dma_addr` to 0, empties the buffer and leaves `dma_req` and `irq` low. `rst` alone keeps the programmed start and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, keeps programmed start and length |
| rst_hard | input | 1 | Synchronous full reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 address, 2 length |
| wr_data | input | DATA_W | Register write byte |
| en_wr | input | 1 | Channel enable/disable strobe |
| en_val | input | 1 | 1 enables, 0 disables |
| cyc_odd | input | 1 | Parity of the current cycle, sampled with `en_wr` |
| dma_req | output | 1 | Fetch request, held until acknowledged |
| dma_addr | output | ADDR_W | Address of the requested byte |
| dma_ack | input | 1 | Fetched byte valid on `dma_data` |
| dma_data | input | DATA_W | Fetched byte |
| buf_take | input | 1 | Output unit consumes the buffer |
| buf_data | output | DATA_W | Sample buffer contents |
| buf_empty | output | 1 | Sample buffer holds no byte |
| irq | output | 1 | End-of-sample interrupt |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, byte-wide data, an address shift of 6 and a length shift of 4. With those values, an address byte of 0xFF places the start 64 bytes below the top of memory. A length byte of 4 (65 bytes) therefore crosses the 0xFFFF to 0x8000 wrap in one run. Length bytes 0 to 2 give runs of 1, 17 and 33 bytes, which are short enough to count every request. The kick delays of 2 and 3 cycles make both parities observable directly.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int CTRL_IRQ_BIT  = 7;
  localparam int CTRL_LOOP_BIT = 6;
endpackage

// File: rtl/sfc_cfg.sv
module sfc_cfg
  import sfc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int ADDR_SHIFT = 6,
  parameter int LEN_SHIFT  = 4,
  parameter logic [ADDR_W-1:0] BASE = 16'hC000,
  localparam int LEN_W = DATA_W + LEN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              rst_hard,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] start_addr,
  output logic [LEN_W-1:0]  start_len,
  output logic              irq_en,
  output logic              loop_en,
  output logic              irq_off
);
  sel_e sel;
  assign sel = sel_e'(wr_sel);

  assign irq_off = wr_en && (sel == SEL_CTRL) && !wr_data[CTRL_IRQ_BIT];

  always_ff @(posedge clk) begin
    if (rst_hard) begin
      start_addr <= BASE;
      start_len  <= LEN_W'(1);
    end else if (wr_en && sel == SEL_ADDR) begin
      start_addr <= BASE | (ADDR_W'(wr_data) << ADDR_SHIFT);
    end else if (wr_en && sel == SEL_LEN) begin
      start_len <= (LEN_W'(wr_data) << LEN_SHIFT) | LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      irq_en  <= 1'b0;
      loop_en <= 1'b0;
    end else if (wr_en && sel == SEL_CTRL) begin
      irq_en  <= wr_data[CTRL_IRQ_BIT];
      loop_en <= wr_data[CTRL_LOOP_BIT];
    end
  end
endmodule

// File: rtl/sfc_kick.sv
module sfc_kick #(
  parameter int EVEN_DLY = 2,
  parameter int ODD_DLY  = 3,
  localparam int MAX_DLY = (EVEN_DLY > ODD_DLY) ? EVEN_DLY : ODD_DLY,
  localparam int CW      = $clog2(MAX_DLY + 1)
) (
  input  logic clk,
  input  logic rst_any,
  input  logic abort,
  input  logic load,
  input  logic odd,
  output logic fire
);
  logic [CW-1:0] cnt;

  assign fire = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst_any || abort) cnt <= '0;
    else if (load)        cnt <= odd ? CW'(ODD_DLY) : CW'(EVEN_DLY);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/sfc_fetch.sv
module sfc_fetch #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12,
  parameter logic [ADDR_W-1:0] WRAP_TO = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              irq_en,
  input  logic              loop_en,
  input  logic              irq_off,
  input  logic              ena,
  input  logic              dis,
  input  logic              kick,
  input  logic              dma_ack,
  input  logic [DATA_W-1:0] dma_data,
  input  logic              buf_take,
  output logic              restart,
  output logic [LEN_W-1:0]  rem,
  output logic              dma_req,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_empty,
  output logic              irq
);
  logic              has_rem, last, take_ok, accept, want_req;
  logic [ADDR_W-1:0] next_addr;

  assign has_rem   = (rem != '0);
  assign last      = (rem == LEN_W'(1));
  assign restart   = ena && !has_rem;
  assign accept    = dma_ack && has_rem && !dis && !ena;
  assign take_ok   = buf_take && !buf_empty;
  assign next_addr = (dma_addr == '1) ? WRAP_TO : dma_addr + ADDR_W'(1);
  assign want_req  = has_rem && ((take_ok) || (kick && buf_empty));

  always_ff @(posedge clk) begin
    if (rst_any) begin
      dma_addr  <= '0;
      rem       <= '0;
      dma_req   <= 1'b0;
    end else if (dis) begin
      rem     <= '0;
      dma_req <= 1'b0;
    end else if (restart) begin
      dma_addr <= start_addr;
      rem      <= start_len;
    end else if (accept) begin
      dma_req <= 1'b0;
      if (last && loop_en) begin
        dma_addr <= start_addr;
        rem      <= start_len;
      end else begin
        dma_addr <= next_addr;
        rem      <= rem - LEN_W'(1);
      end
    end else if (want_req) begin
      dma_req <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      buf_data  <= '0;
      buf_empty <= 1'b1;
    end else if (accept) begin
      buf_data  <= dma_data;
      buf_empty <= 1'b0;
    end else if (take_ok) begin
      buf_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any)                          irq <= 1'b0;
    else if (accept && last && !loop_en && irq_en) irq <= 1'b1;
    else if (irq_off)                     irq <= 1'b0;
  end
endmodule

// File: rtl/sample_fetch_ctrl.sv
module sample_fetch_ctrl #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int ADDR_SHIFT = 6,
  parameter int LEN_SHIFT  = 4,
  parameter logic [ADDR_W-1:0] BASE    = 16'hC000,
  parameter logic [ADDR_W-1:0] WRAP_TO = 16'h8000,
  parameter int EVEN_DLY   = 2,
  parameter int ODD_DLY    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_hard,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              en_wr,
  input  logic              en_val,
  input  logic              cyc_odd,
  output logic              dma_req,
  output logic [ADDR_W-1:0] dma_addr,
  input  logic              dma_ack,
  input  logic [DATA_W-1:0] dma_data,
  input  logic              buf_take,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_empty,
  output logic              irq
);
  localparam int LEN_W = DATA_W + LEN_SHIFT;

  logic              rst_any, ena, dis, kick, restart;
  logic              irq_en, loop_en, irq_off;
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  start_len, rem_w;

  assign rst_any = rst | rst_hard;
  assign ena     = en_wr &  en_val;
  assign dis     = en_wr & ~en_val;

  sfc_cfg #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT),
    .LEN_SHIFT(LEN_SHIFT), .BASE(BASE)
  ) u_cfg (
    .clk(clk), .rst_any(rst_any), .rst_hard(rst_hard),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start_addr(start_addr), .start_len(start_len),
    .irq_en(irq_en), .loop_en(loop_en), .irq_off(irq_off)
  );

  sfc_kick #(.EVEN_DLY(EVEN_DLY), .ODD_DLY(ODD_DLY)) u_kick (
    .clk(clk), .rst_any(rst_any), .abort(dis), .load(restart),
    .odd(cyc_odd), .fire(kick)
  );

  sfc_fetch #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .WRAP_TO(WRAP_TO)
  ) u_fetch (
    .clk(clk), .rst_any(rst_any),
    .start_addr(start_addr), .start_len(start_len),
    .irq_en(irq_en), .loop_en(loop_en), .irq_off(irq_off),
    .ena(ena), .dis(dis), .kick(kick),
    .dma_ack(dma_ack), .dma_data(dma_data), .buf_take(buf_take),
    .restart(restart), .rem(rem_w),
    .dma_req(dma_req), .dma_addr(dma_addr),
    .buf_data(buf_data), .buf_empty(buf_empty), .irq(irq)
  );
endmodule

// File: rtl/sample_fetch_ctrl_chk.sv
module sample_fetch_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12,
  parameter logic [ADDR_W-1:0] WRAP_TO = 16'h8000
) (
  input logic              clk,
  input logic              rst,
  input logic              rst_hard,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              en_wr,
  input logic              en_val,
  input logic              dma_req,
  input logic [ADDR_W-1:0] dma_addr,
  input logic              dma_ack,
  input logic              buf_take,
  input logic [DATA_W-1:0] buf_data,
  input logic              buf_empty,
  input logic              irq,
  input logic [LEN_W-1:0]  rem_q
);
  logic rs;
  assign rs = rst | rst_hard;

  p_irq_clear_r1: assert property (@(posedge clk) disable iff (rs)
    wr_en && wr_sel == 2'd0 && !wr_data[7] && !dma_ack |=> !irq);

  p_wrap_r5: assert property (@(posedge clk) disable iff (rs)
    dma_ack && rem_q > LEN_W'(1) && dma_addr == '1 && !en_wr |=> dma_addr == WRAP_TO);

  p_disable_r8: assert property (@(posedge clk) disable iff (rs)
    en_wr && !en_val |=> !dma_req && rem_q == '0);

  p_full_noreq_r10: assert property (@(posedge clk) disable iff (rs)
    !buf_empty |-> !dma_req);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rs)
    dma_req && !dma_ack && !(en_wr && !en_val) |=> dma_req);

  p_addr_stable_r11: assert property (@(posedge clk) disable iff (rs)
    dma_req && !dma_ack |=> $stable(dma_addr));

  p_ignore_ack_r12: assert property (@(posedge clk) disable iff (rs)
    dma_ack && rem_q == '0 && !buf_take |=> $stable(buf_data) && $stable(buf_empty));
endmodule

bind sample_fetch_ctrl sample_fetch_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .WRAP_TO(WRAP_TO)
) u_chk (
  .clk(clk), .rst(rst), .rst_hard(rst_hard),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .en_wr(en_wr), .en_val(en_val),
  .dma_req(dma_req), .dma_addr(dma_addr), .dma_ack(dma_ack),
  .buf_take(buf_take), .buf_data(buf_data), .buf_empty(buf_empty),
  .irq(irq), .rem_q(rem_w)
);

// File: tb/sample_fetch_ctrl_tb.sv
module sample_fetch_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b0, rst_hard = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [7:0]  wr_data = 8'h00;
  logic        en_wr = 1'b0, en_val = 1'b0, cyc_odd = 1'b0;
  logic        dma_req, dma_ack = 1'b0;
  logic [15:0] dma_addr;
  logic [7:0]  dma_data = 8'h00, buf_data;
  logic        buf_take = 1'b0, buf_empty, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sample_fetch_ctrl u_dut (
    .clk(clk), .rst(rst), .rst_hard(rst_hard),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .en_wr(en_wr), .en_val(en_val), .cyc_odd(cyc_odd),
    .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_ack(dma_ack), .dma_data(dma_data),
    .buf_take(buf_take), .buf_data(buf_data), .buf_empty(buf_empty),
    .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  l;
    logic        odd;
    logic [15:0] addr;
    logic [11:0] len;
    logic [1:0]  dly;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{8'h00, 8'h00, 1'b0, 16'hC000, 12'd1,  2'd2},
    '{8'h10, 8'h01, 1'b1, 16'hC400, 12'd17, 2'd3},
    '{8'h3F, 8'h02, 1'b0, 16'hCFC0, 12'd33, 2'd2},
    '{8'h80, 8'h00, 1'b1, 16'hE000, 12'd1,  2'd3}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    cyc();
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic enable(input logic v, input logic odd);
    en_wr = 1'b1; en_val = v; cyc_odd = odd;
    cyc();
    en_wr = 1'b0;
  endtask

  task automatic wait_req(output int d);
    d = 0;
    while (!dma_req && d < 50) begin cyc(); d++; end
  endtask

  task automatic serve(input logic [7:0] d);
    dma_ack = 1'b1; dma_data = d;
    cyc();
    dma_ack = 1'b0;
  endtask

  task automatic take();
    buf_take = 1'b1;
    cyc();
    buf_take = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d, n;
    logic [15:0] a0;
    repeat (3) cyc();
    rst_hard = 1'b0;
    cyc();
    // R13: reset state
    chk(dma_req == 0,    "R13", "req after reset", dma_req, 0);
    chk(dma_addr == 0,   "R13", "addr after reset", dma_addr, 0);
    chk(buf_empty == 1,  "R13", "empty after reset", buf_empty, 1);
    chk(irq == 0,        "R13", "irq after reset", irq, 0);
    // R13: hard reset defaults C000 / 1 byte
    enable(1'b1, 1'b0);
    wait_req(d);
    chk(dma_addr == 16'hC000, "R13", "default start", dma_addr, 16'hC000);
    serve(8'h11); take();
    chk(dma_req == 0, "R13", "default length 1", dma_req, 0);

    // table: R2 R3 R6 R9 R4 R10 R1
    foreach (VEC[i]) begin
      wr(2'd0, 8'h80);
      wr(2'd1, VEC[i].a);
      wr(2'd2, VEC[i].l);
      enable(1'b1, VEC[i].odd);
      wait_req(d);
      chk(d == int'(VEC[i].dly), "R9", "kick delay", d, VEC[i].dly);
      n = 0;
      do begin
        chk(dma_addr == VEC[i].addr + 16'(n), "R2", "fetch address", dma_addr, VEC[i].addr + 16'(n));
        serve(8'(n + 8'h40));
        chk(buf_data == 8'(n + 8'h40) && !buf_empty && !dma_req, "R4", "buffer fill",
            {buf_data, buf_empty, dma_req}, {8'(n + 8'h40), 2'b00});
        n++;
        take();
        chk(buf_empty == 1, "R10", "consume empties", buf_empty, 1);
      end while (dma_req && n < 5000);
      chk(n == int'(VEC[i].len), "R3", "byte count", n, VEC[i].len);
      chk(irq == 1, "R6", "irq at end", irq, 1);
      wr(2'd0, 8'h00);
      chk(irq == 0, "R1", "irq cleared by control", irq, 0);
    end

    // R5: wrap 0xFFFF -> 0x8000, irq disabled
    wr(2'd1, 8'hFF); wr(2'd2, 8'h04);
    enable(1'b1, 1'b0);
    wait_req(d);
    for (int k = 0; k < 64; k++) begin
      if (k == 0 || k == 63)
        chk(dma_addr == 16'hFFC0 + 16'(k), "R5", "pre-wrap address", dma_addr, 16'hFFC0 + 16'(k));
      serve(8'(k)); take();
    end
    chk(dma_addr == 16'h8000 && dma_req, "R5", "wrapped address", dma_addr, 16'h8000);
    serve(8'h55); take();
    chk(irq == 0 && dma_req == 0, "R6", "no irq when disabled", {irq, dma_req}, 0);

    // R7: loop with irq enabled
    wr(2'd0, 8'hC0); wr(2'd1, 8'h02); wr(2'd2, 8'h00);
    enable(1'b1, 1'b0);
    wait_req(d);
    chk(dma_addr == 16'hC080, "R7", "loop first address", dma_addr, 16'hC080);
    serve(8'h21);
    chk(dma_addr == 16'hC080, "R7", "address reloaded", dma_addr, 16'hC080);
    take();
    chk(dma_req == 1, "R7", "loop re-request", dma_req, 1);
    serve(8'h22); take();
    chk(irq == 0, "R7", "no irq while looping", irq, 0);
    // R11: request held without ack
    repeat (5) cyc();
    chk(dma_req == 1 && dma_addr == 16'hC080, "R11", "request held", {dma_req, dma_addr}, {1'b1, 16'hC080});
    // R8: disable drops request
    enable(1'b0, 1'b0);
    chk(dma_req == 0, "R8", "disable drops req", dma_req, 0);
    // R12: ack with nothing remaining ignored
    serve(8'hAA);
    chk(buf_empty == 1 && buf_data == 8'h22, "R12", "ignored ack", {buf_empty, buf_data}, {1'b1, 8'h22});
    take();
    chk(dma_req == 0, "R8", "no request after disable", dma_req, 0);
    // R8: enable restarts from start, odd parity
    enable(1'b1, 1'b1);
    wait_req(d);
    chk(d == 3 && dma_addr == 16'hC080, "R8", "restart after disable", dma_addr, 16'hC080);
    wr(2'd0, 8'h00);
    serve(8'h23); take();

    // R8: enable while bytes remain has no effect
    wr(2'd2, 8'h01);
    enable(1'b1, 1'b0);
    wait_req(d);
    serve(8'h01); take();
    serve(8'h02); take();
    a0 = dma_addr;
    chk(a0 == 16'hC082, "R4", "address advanced", a0, 16'hC082);
    enable(1'b1, 1'b1);
    cyc();
    chk(dma_addr == 16'hC082 && dma_req, "R8", "enable while active", dma_addr, 16'hC082);
    enable(1'b0, 1'b0);

    // R13: soft reset keeps programmed start
    wr(2'd1, 8'h05);
    rst = 1'b1; cyc(); rst = 1'b0;
    chk(dma_addr == 0 && buf_empty && !irq && !dma_req, "R13", "soft reset state",
        {dma_addr, buf_empty, irq, dma_req}, {16'h0, 3'b100});
    enable(1'b1, 1'b0);
    wait_req(d);
    chk(dma_addr == 16'hC140, "R13", "start kept over soft reset", dma_addr, 16'hC140);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule